// File: doc/BRIEF.md
# Sensor-Hub Host Register Bank

This block is the byte-wide register file that a host processor reaches through a serial slave port on a sensor-hub controller. The serial front end, which is not part of this block, turns bus traffic into byte transactions. Each transaction is an address byte, followed by a burst of data bytes that the front end marks with write or read strobes. The block holds the host-owned settings: configuration, two interrupt masks, and the command, parameter and command-entry bytes. It also holds the controller-owned reporting registers: status, error codes, interrupt requests and results. A window at a fixed address pops bytes from a small result FIFO.

The local controller sees the same map through a parallel port. It writes status, error, request and result bytes and reads back the command and parameter bytes. It learns about a new command from a pending flag and acknowledges it with a one-cycle strobe. The block drives an active-low interrupt line to the host. That line is either a fixed-width pulse or a level, as the configuration selects.

Top module: `hostreg_bank`

## Requirements
- R1: After reset the configuration reads 00h and both masks read FFh. Status, requests, errors, commands, parameters, entry and results read 00h. `host_irq_n` is 1, `fifo_underflow` is 0 and `cmd_pending` is 0.
- R2: An address byte loads its bits 6:0 into the register pointer. Its bit 7 marks a read burst, so a register written at address A is read at A+80h. Write strobes in a read burst are ignored and do not move the pointer. `h_rdata` always shows the register at the pointer.
- R3: When configuration bit 7 is 0, the pointer advances by one after each accepted data byte and wraps from 7Fh to 00h. When bit 7 is 1, the pointer stays on the same address for the whole burst.
- R4: Configuration bit 6 drives `spi_3wire`. Configuration bit 2 selects the interrupt style: 1 gives a level, 0 gives a pulse.
- R5: The host can write only 00h–02h and 10h–1Fh. At 1Fh only bit 0 is stored, and it reads back with the upper bits at 0. Host writes to any other address are ignored, and reserved addresses read 00h.
- R6: Request registers sit at 09h (bits 7:0) and 0Ah (bits 15:8). A controller write ORs its data into the register. A host read of either register clears all of its bits.
- R7: If a controller set and a host clear-on-read reach the same request register in one cycle, the new set bits survive and the old bits are cleared.
- R8: Entry bit 0 appears on `cmd_pending`. `c_cmd_ack` clears it, unless a host write to 1Fh lands in the same cycle, in which case the host write wins.
- R9: The controller writes status at 08h, errors at 0Bh/0Ch and results at 20h–3Fh. The host reads these at the read alias. `c_rdata` shows the register at `c_addr` with no side effect.
- R10: In level mode, `host_irq_n` is 0 whenever any request bit with a mask bit of 1 is set. A mask bit of 0 blocks its request bit.
- R11: In pulse mode, a 0-to-1 change of any unmasked request bit drives `host_irq_n` low for exactly PULSE_LEN cycles. The pulse starts one cycle after the request register changes. A masked bit gives no pulse.
- R12: The controller pushes bytes into the FIFO. Each host read at 40h returns the oldest byte and pops it. A push into a full FIFO is dropped.
- R13: A host read at 40h while the FIFO is empty returns 00h and sets `fifo_underflow`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_start | input | 1 | Address byte strobe |
| h_byte | input | 8 | Address byte: bit 7 marks a read, bits 6:0 are the address |
| h_wr | input | 1 | Host data write strobe |
| h_wdata | input | 8 | Host write data |
| h_rd | input | 1 | Host data read strobe; commits clear-on-read, pop and pointer advance |
| h_rdata | output | 8 | Register at the host pointer |
| host_irq_n | output | 1 | Active-low interrupt to the host |
| spi_3wire | output | 1 | Serial wiring selection for the front end |
| c_we | input | 1 | Controller write strobe |
| c_addr | input | 7 | Controller register address |
| c_wdata | input | 8 | Controller write data |
| c_rdata | output | 8 | Register at `c_addr` |
| c_fifo_push | input | 1 | Push one byte into the result FIFO |
| c_fifo_data | input | 8 | Byte to push |
| cmd_pending | output | 1 | Host has posted a command |
| c_cmd_ack | input | 1 | Controller accepts the posted command |
| fifo_underflow | output | 1 | Sticky flag for a read of an empty FIFO |

## Verification
The bench builds the block with FIFO_DEPTH at 4 and PULSE_LEN at 4. A depth of 4 lets a few pushes fill the FIFO, so the dropped fifth push and the underflow read that follows the drain are both reached in a short run. A pulse length of 4 can be counted cycle by cycle, so the check finds an edge that is one cycle early or late. Same-cycle collisions between host and controller strobes are driven on purpose, both on the request registers and on the entry bit.

// File: rtl/hostreg_pkg.sv
// Package: shared byte type, register address map and configuration bit
// positions for the host register bank. Assumes a 7-bit register space.
package hostreg_pkg;
    typedef logic [7:0] byte_t;
    typedef logic [6:0] regaddr_t;

    localparam regaddr_t A_CFG    = 7'h00;
    localparam regaddr_t A_MSK0   = 7'h01;
    localparam regaddr_t A_MSK1   = 7'h02;
    localparam regaddr_t A_STAT   = 7'h08;
    localparam regaddr_t A_REQ0   = 7'h09;
    localparam regaddr_t A_REQ1   = 7'h0A;
    localparam regaddr_t A_ERR0   = 7'h0B;
    localparam regaddr_t A_ERR1   = 7'h0C;
    localparam regaddr_t A_CMD_LO = 7'h10;
    localparam regaddr_t A_ENT    = 7'h1F;
    localparam regaddr_t A_RES_LO = 7'h20;
    localparam regaddr_t A_RES_HI = 7'h3F;
    localparam regaddr_t A_FIFO   = 7'h40;

    localparam int CFG_FIXED_BIT = 7;
    localparam int CFG_SPI3W_BIT = 6;
    localparam int CFG_LEVEL_BIT = 2;

    localparam int N_CMDPRM = int'(A_ENT) - int'(A_CMD_LO);
    localparam int N_RES    = int'(A_RES_HI) - int'(A_RES_LO) + 1;
    localparam int CMD_IW   = $clog2(N_CMDPRM);
    localparam int RES_IW   = $clog2(N_RES);
endpackage

// File: rtl/hostreg_fifo.sv
// Module: result FIFO behind the host pop window.
// Assumes one push and one pop per cycle at most. A push while the FIFO is
// full is dropped, and a pop while it is empty does nothing. The storage has
// no reset, so its contents are undefined until written.
module hostreg_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          full, do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign dout    = mem[rp];

    // Storage write: no reset on the data array.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R12: occupancy never exceeds the depth.
    p_count_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    // R12: a push into a full FIFO with no pop leaves the occupancy unchanged.
    p_full_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/hostreg_irq.sv
// Module: host interrupt generator.
// Level style: low while any unmasked request bit is set. Pulse style: low
// for PULSE_LEN cycles after any unmasked request bit goes from 0 to 1. A new
// rise during a pulse restarts the count. Assumes request and mask come from
// registers.
module hostreg_irq #(
    parameter int PULSE_LEN = 4,
    parameter int W         = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] req,
    input  logic [W-1:0] msk,
    input  logic         level_mode,
    output logic         irq_n
);
    localparam int CW = $clog2(PULSE_LEN + 1);

    logic [W-1:0]  live, prev;
    logic [CW-1:0] cnt;
    logic          rise;

    assign live  = req & msk;
    assign rise  = |(live & ~prev);
    assign irq_n = level_mode ? ~(|live) : (cnt == '0);

    // Track the unmasked request vector and run the pulse counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= '0;
            cnt  <= '0;
        end else begin
            prev <= live;
            if (rise)           cnt <= CW'(PULSE_LEN);
            else if (cnt != '0) cnt <= cnt - 1'b1;
        end
    end

    // R11: the pulse counter never runs past its length.
    p_pulse_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(PULSE_LEN));

    // R11: in pulse style, a fresh unmasked rise drives the line low next cycle.
    p_pulse_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_mode && rise) |=> (level_mode || !irq_n));
endmodule

// File: rtl/hostreg_bank.sv
// Module: host-facing register bank of a sensor hub.
// Assumes the serial front end delivers one strobe per cycle. An address byte
// (h_start) takes priority over data strobes in the same cycle. The host read
// data is combinational from the pointer, and h_rd commits the read's side
// effects: clear-on-read, FIFO pop and pointer advance.
module hostreg_bank
    import hostreg_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int PULSE_LEN  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       h_start,
    input  logic [7:0] h_byte,
    input  logic       h_wr,
    input  logic [7:0] h_wdata,
    input  logic       h_rd,
    output logic [7:0] h_rdata,
    output logic       host_irq_n,
    output logic       spi_3wire,
    input  logic       c_we,
    input  logic [6:0] c_addr,
    input  logic [7:0] c_wdata,
    output logic [7:0] c_rdata,
    input  logic       c_fifo_push,
    input  logic [7:0] c_fifo_data,
    output logic       cmd_pending,
    input  logic       c_cmd_ack,
    output logic       fifo_underflow
);
    regaddr_t ptr;
    logic     rd_dir;
    byte_t    cfg, msk0, msk1, stat, req0, req1, err0, err1;
    byte_t    cmdprm [N_CMDPRM];
    byte_t    res    [N_RES];
    logic     ent;
    logic     und;
    logic     fifo_empty;
    byte_t    fifo_dout;
    logic     wr_x, rd_x, xfer, fifo_pop, host_ent_wr;
    byte_t    set0, set1, clr0, clr1;

    assign wr_x        = h_wr & ~h_start & ~rd_dir;
    assign rd_x        = h_rd & ~h_start & rd_dir;
    assign xfer        = wr_x | rd_x;
    assign fifo_pop    = rd_x && (ptr == A_FIFO);
    assign host_ent_wr = wr_x && (ptr == A_ENT);
    assign set0 = (c_we && c_addr == A_REQ0) ? c_wdata : 8'h00;
    assign set1 = (c_we && c_addr == A_REQ1) ? c_wdata : 8'h00;
    assign clr0 = (rd_x && ptr == A_REQ0) ? 8'hFF : 8'h00;
    assign clr1 = (rd_x && ptr == A_REQ1) ? 8'hFF : 8'h00;

    assign spi_3wire      = cfg[CFG_SPI3W_BIT];
    assign cmd_pending    = ent;
    assign fifo_underflow = und;

    // Address decode shared by both read ports; reserved space reads zero.
    function automatic byte_t read_reg(input regaddr_t a);
        byte_t r;
        r = 8'h00;
        if (a >= A_CMD_LO && a < A_ENT)
            r = cmdprm[CMD_IW'(a - A_CMD_LO)];
        else if (a >= A_RES_LO && a <= A_RES_HI)
            r = res[RES_IW'(a - A_RES_LO)];
        else begin
            case (a)
                A_CFG:   r = cfg;
                A_MSK0:  r = msk0;
                A_MSK1:  r = msk1;
                A_STAT:  r = stat;
                A_REQ0:  r = req0;
                A_REQ1:  r = req1;
                A_ERR0:  r = err0;
                A_ERR1:  r = err1;
                A_ENT:   r = {7'b0, ent};
                A_FIFO:  r = fifo_empty ? 8'h00 : fifo_dout;
                default: r = 8'h00;
            endcase
        end
        return r;
    endfunction

    // Read muxes for host (at pointer) and controller (at its address).
    always_comb begin
        h_rdata = read_reg(ptr);
        c_rdata = read_reg(c_addr);
    end

    // Register pointer: load on address byte, then advance or hold per mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr    <= '0;
            rd_dir <= 1'b0;
        end else if (h_start) begin
            ptr    <= h_byte[6:0];
            rd_dir <= h_byte[7];
        end else if (xfer && !cfg[CFG_FIXED_BIT]) begin
            ptr <= ptr + 1'b1;
        end
    end

    // Host-owned configuration and mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg  <= 8'h00;
            msk0 <= 8'hFF;
            msk1 <= 8'hFF;
        end else if (wr_x) begin
            if (ptr == A_CFG)  cfg  <= h_wdata;
            if (ptr == A_MSK0) msk0 <= h_wdata;
            if (ptr == A_MSK1) msk1 <= h_wdata;
        end
    end

    // Command and parameter bytes written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_CMDPRM; i++) cmdprm[i] <= 8'h00;
        end else if (wr_x && ptr >= A_CMD_LO && ptr < A_ENT) begin
            cmdprm[CMD_IW'(ptr - A_CMD_LO)] <= h_wdata;
        end
    end

    // Command-entry handshake: a host write wins over a same-cycle ack.
    always_ff @(posedge clk) begin
        if (!rst_n)          ent <= 1'b0;
        else if (host_ent_wr) ent <= h_wdata[0];
        else if (c_cmd_ack)  ent <= 1'b0;
    end

    // Request registers: controller sets OR in over host clear-on-read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req0 <= 8'h00;
            req1 <= 8'h00;
        end else begin
            req0 <= (req0 & ~clr0) | set0;
            req1 <= (req1 & ~clr1) | set1;
        end
    end

    // Controller-owned status, error and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat <= 8'h00;
            err0 <= 8'h00;
            err1 <= 8'h00;
            for (int i = 0; i < N_RES; i++) res[i] <= 8'h00;
        end else if (c_we) begin
            if (c_addr == A_STAT) stat <= c_wdata;
            if (c_addr == A_ERR0) err0 <= c_wdata;
            if (c_addr == A_ERR1) err1 <= c_wdata;
            if (c_addr >= A_RES_LO && c_addr <= A_RES_HI)
                res[RES_IW'(c_addr - A_RES_LO)] <= c_wdata;
        end
    end

    // Sticky underflow on a host pop of an empty FIFO.
    always_ff @(posedge clk) begin
        if (!rst_n)                    und <= 1'b0;
        else if (fifo_pop && fifo_empty) und <= 1'b1;
    end

    hostreg_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (c_fifo_push),
        .din   (c_fifo_data),
        .pop   (fifo_pop),
        .dout  (fifo_dout),
        .empty (fifo_empty)
    );

    hostreg_irq #(.PULSE_LEN(PULSE_LEN), .W(16)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        ({req1, req0}),
        .msk        ({msk1, msk0}),
        .level_mode (cfg[CFG_LEVEL_BIT]),
        .irq_n      (host_irq_n)
    );

    // R3: fixed-address mode keeps the pointer through a data byte.
    p_hold_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && cfg[CFG_FIXED_BIT]) |=> (ptr == $past(ptr)));

    // R6: a host read of request register 0 with no set leaves it clear.
    p_clear_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_x && ptr == A_REQ0 && !(c_we && c_addr == A_REQ0)) |=> (req0 == 8'h00));

    // R7: bits set by the controller survive a same-cycle clear.
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (c_we && c_addr == A_REQ0) |=> ((req0 & $past(c_wdata)) == $past(c_wdata)));

    // R8: an ack without a competing host write drops the pending flag.
    p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (c_cmd_ack && !host_ent_wr) |=> !cmd_pending);

    // R13: a read of the empty window raises the flag, and the flag stays set.
    p_pop_empty_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_pop && fifo_empty) |=> fifo_underflow);
    p_underflow_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_underflow |=> fifo_underflow);
endmodule

// File: tb/hostreg_bank_test.sv
`timescale 1ns/1ps
// Bench: a vector table walked by one loop, then directed tests for the
// pointer modes, clear-on-read collisions, interrupt styles, the command
// handshake and the FIFO window.
module hostreg_bank_test;
    localparam int DEPTH = 4;
    localparam int PLEN  = 4;

    logic       clk = 0, rst_n = 0;
    logic       h_start = 0, h_wr = 0, h_rd = 0;
    logic [7:0] h_byte = 0, h_wdata = 0;
    logic [7:0] h_rdata, c_rdata;
    logic       host_irq_n, spi_3wire, cmd_pending, fifo_underflow;
    logic       c_we = 0, c_fifo_push = 0, c_cmd_ack = 0;
    logic [6:0] c_addr = 0;
    logic [7:0] c_wdata = 0, c_fifo_data = 0;

    int  total = 0, bad = 0;
    bit  done = 0;

    always #2.5 clk = ~clk;

    hostreg_bank #(.FIFO_DEPTH(DEPTH), .PULSE_LEN(PLEN)) uut (
        .clk(clk), .rst_n(rst_n),
        .h_start(h_start), .h_byte(h_byte), .h_wr(h_wr), .h_wdata(h_wdata),
        .h_rd(h_rd), .h_rdata(h_rdata),
        .host_irq_n(host_irq_n), .spi_3wire(spi_3wire),
        .c_we(c_we), .c_addr(c_addr), .c_wdata(c_wdata), .c_rdata(c_rdata),
        .c_fifo_push(c_fifo_push), .c_fifo_data(c_fifo_data),
        .cmd_pending(cmd_pending), .c_cmd_ack(c_cmd_ack),
        .fifo_underflow(fifo_underflow)
    );

    // Vector fields: {req[3:0], op[1:0], addr[7:0], data[7:0], expect[7:0]}
    localparam logic [1:0] OP_HW = 2'd0, OP_HR = 2'd1, OP_CW = 2'd2, OP_CR = 2'd3;
    localparam int NV = 22;
    localparam logic [29:0] VEC [NV] = '{
        {4'd5, OP_HW, 8'h01, 8'hF0, 8'h00},  // R5 mask 0 write
        {4'd5, OP_HR, 8'h81, 8'h00, 8'hF0},  // R5
        {4'd2, OP_HW, 8'h12, 8'h5A, 8'h00},  // R2 param write
        {4'd2, OP_HR, 8'h92, 8'h00, 8'h5A},  // R2 read alias
        {4'd9, OP_CR, 8'h12, 8'h00, 8'h5A},  // R9 controller view
        {4'd5, OP_HW, 8'h05, 8'hAA, 8'h00},  // R5 reserved write
        {4'd5, OP_HR, 8'h85, 8'h00, 8'h00},  // R5 reserved reads zero
        {4'd5, OP_HW, 8'h20, 8'h77, 8'h00},  // R5 result is read-only to host
        {4'd5, OP_HR, 8'hA0, 8'h00, 8'h00},  // R5
        {4'd9, OP_CW, 8'h21, 8'hC3, 8'h00},  // R9 result write
        {4'd9, OP_HR, 8'hA1, 8'h00, 8'hC3},  // R9
        {4'd9, OP_CW, 8'h08, 8'h3C, 8'h00},  // R9 status write
        {4'd9, OP_HR, 8'h88, 8'h00, 8'h3C},  // R9
        {4'd9, OP_CW, 8'h0C, 8'h99, 8'h00},  // R9 error write
        {4'd9, OP_HR, 8'h8C, 8'h00, 8'h99},  // R9
        {4'd5, OP_HW, 8'h1E, 8'h11, 8'h00},  // R5 top parameter
        {4'd5, OP_HR, 8'h9E, 8'h00, 8'h11},  // R5
        {4'd5, OP_HW, 8'h41, 8'h55, 8'h00},  // R5 reserved above window
        {4'd5, OP_HR, 8'hC1, 8'h00, 8'h00},  // R5
        {4'd5, OP_HW, 8'h02, 8'h0F, 8'h00},  // R5 mask 1 write
        {4'd5, OP_HR, 8'h82, 8'h00, 8'h0F},  // R5
        {4'd5, OP_HW, 8'h02, 8'hFF, 8'h00}   // R5 restore mask 1
    };

    task automatic check(input int rq, input logic [7:0] act, input logic [7:0] exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s: actual=%02h expected=%02h", rq, what, act, exp);
        end
    endtask

    task automatic h_addr(input logic [7:0] a);
        h_start = 1; h_byte = a;
        @(posedge clk); #1;
        h_start = 0;
    endtask

    task automatic h_write(input logic [7:0] d);
        h_wr = 1; h_wdata = d;
        @(posedge clk); #1;
        h_wr = 0;
    endtask

    task automatic h_read(output logic [7:0] d);
        #1; d = h_rdata;
        h_rd = 1;
        @(posedge clk); #1;
        h_rd = 0;
    endtask

    task automatic c_write(input logic [6:0] a, input logic [7:0] d);
        c_we = 1; c_addr = a; c_wdata = d;
        @(posedge clk); #1;
        c_we = 0;
    endtask

    task automatic c_push(input logic [7:0] d);
        c_fifo_push = 1; c_fifo_data = d;
        @(posedge clk); #1;
        c_fifo_push = 0;
    endtask

    task automatic cfg_set(input logic [7:0] v);
        h_addr(8'h00); h_write(v);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int lows;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        #1;
        // R1 reset state
        check(1, {7'b0, host_irq_n}, 8'h01, "irq idle high");
        check(1, {7'b0, fifo_underflow}, 8'h00, "underflow clear");
        check(1, {7'b0, cmd_pending}, 8'h00, "no command");
        h_addr(8'h80); h_read(d); check(1, d, 8'h00, "cfg reset");   // R1
        h_read(d); check(1, d, 8'hFF, "mask0 reset");                // R1
        h_read(d); check(1, d, 8'hFF, "mask1 reset");                // R1
        h_addr(8'h89); h_read(d); check(1, d, 8'h00, "req0 reset");  // R1

        // Vector table
        for (int i = 0; i < NV; i++) begin
            logic [29:0] v;
            v = VEC[i];
            case (v[25:24])
                OP_HW: begin h_addr(v[23:16]); h_write(v[15:8]); end
                OP_HR: begin h_addr(v[23:16]); h_read(d); check(int'(v[29:26]), d, v[7:0], $sformatf("vector %0d", i)); end
                OP_CW: c_write(v[22:16], v[15:8]);
                default: begin c_addr = v[22:16]; #1; check(int'(v[29:26]), c_rdata, v[7:0], $sformatf("vector %0d", i)); end
            endcase
        end

        // R3 auto-increment burst
        h_addr(8'h13); h_write(8'h01); h_write(8'h02); h_write(8'h03);
        h_addr(8'h93); h_read(d); check(3, d, 8'h01, "burst byte 0");
        h_read(d); check(3, d, 8'h02, "burst byte 1");
        h_read(d); check(3, d, 8'h03, "burst byte 2");

        // R3 wrap from 7Fh to 00h, landing on config; R4 3-wire bit
        h_addr(8'h7F); h_write(8'h00); h_write(8'h40);
        check(4, {7'b0, spi_3wire}, 8'h01, "3-wire select");
        h_addr(8'h80); h_read(d); check(3, d, 8'h40, "wrap wrote config");
        cfg_set(8'h00);

        // R3 fixed-address mode
        cfg_set(8'h80);
        h_addr(8'h16); h_write(8'hA1); h_write(8'hB2); h_write(8'hC3);
        h_addr(8'h96); h_read(d); check(3, d, 8'hC3, "fixed last write");
        h_read(d); check(3, d, 8'hC3, "fixed reread");
        h_addr(8'h97); h_read(d); check(3, d, 8'h00, "neighbour untouched");
        cfg_set(8'h00);

        // R2 write strobes ignored inside a read burst
        h_addr(8'h92); h_write(8'hEE); h_read(d);
        check(2, d, 8'h5A, "write in read burst ignored");

        // R6 set by OR, clear on read
        c_write(7'h09, 8'h05); c_write(7'h09, 8'h02);
        h_addr(8'h89); h_read(d); check(6, d, 8'h07, "req0 OR set");
        h_addr(8'h89); h_read(d); check(6, d, 8'h00, "req0 cleared by read");

        // R7 set and clear in the same cycle
        c_write(7'h0A, 8'h03);
        h_addr(8'h8A);
        #1; d = h_rdata;
        h_rd = 1; c_we = 1; c_addr = 7'h0A; c_wdata = 8'h01;
        @(posedge clk); #1; h_rd = 0; c_we = 0;
        check(7, d, 8'h03, "collision read value");
        h_addr(8'h8A); h_read(d); check(7, d, 8'h01, "set survives clear");

        // R10 level mode with a mask
        h_addr(8'h00); h_write(8'h04); h_write(8'hFE);
        c_write(7'h09, 8'h01); #1;
        check(10, {7'b0, host_irq_n}, 8'h01, "masked bit no irq");
        c_write(7'h09, 8'h02); #1;
        check(10, {7'b0, host_irq_n}, 8'h00, "unmasked bit irq low");
        h_addr(8'h89); h_read(d); #1;
        check(10, {7'b0, host_irq_n}, 8'h01, "irq released after read");
        h_addr(8'h01); h_write(8'hFF);

        // R11 pulse mode: exact width
        cfg_set(8'h00);
        c_write(7'h09, 8'h04);
        lows = 0;
        for (int k = 0; k < 10; k++) begin
            @(posedge clk); #1;
            if (!host_irq_n) lows++;
        end
        check(11, 8'(lows), 8'(PLEN), "pulse width");
        h_addr(8'h89); h_read(d);
        // R11 masked bit gives no pulse
        h_addr(8'h01); h_write(8'hFB);
        c_write(7'h09, 8'h04);
        lows = 0;
        for (int k = 0; k < 10; k++) begin
            @(posedge clk); #1;
            if (!host_irq_n) lows++;
        end
        check(11, 8'(lows), 8'h00, "masked rise no pulse");
        h_addr(8'h89); h_read(d);
        h_addr(8'h01); h_write(8'hFF);

        // R8 command entry handshake
        h_addr(8'h1F); h_write(8'hFF);
        check(8, {7'b0, cmd_pending}, 8'h01, "command posted");
        h_addr(8'h9F); h_read(d); check(5, d, 8'h01, "entry keeps bit 0 only"); // R5
        c_cmd_ack = 1; @(posedge clk); #1; c_cmd_ack = 0;
        check(8, {7'b0, cmd_pending}, 8'h00, "ack clears");
        h_addr(8'h1F);
        h_wr = 1; h_wdata = 8'h01; c_cmd_ack = 1;
        @(posedge clk); #1; h_wr = 0; c_cmd_ack = 0;
        check(8, {7'b0, cmd_pending}, 8'h01, "host write beats ack");
        c_cmd_ack = 1; @(posedge clk); #1; c_cmd_ack = 0;

        // R12 FIFO pops in order, in fixed mode
        cfg_set(8'h80);
        c_push(8'hA1); c_push(8'hA2); c_push(8'hA3);
        h_addr(8'hC0);
        h_read(d); check(12, d, 8'hA1, "fifo pop 0");
        h_read(d); check(12, d, 8'hA2, "fifo pop 1");
        h_read(d); check(12, d, 8'hA3, "fifo pop 2");
        check(13, {7'b0, fifo_underflow}, 8'h00, "no underflow yet");  // R13
        h_read(d); check(13, d, 8'h00, "empty read zero");            // R13
        check(13, {7'b0, fifo_underflow}, 8'h01, "underflow set");     // R13
        // R12 push into a full FIFO is dropped
        for (int k = 0; k < DEPTH + 1; k++) c_push(8'(8'h10 + k));
        for (int k = 0; k < DEPTH; k++) begin
            h_read(d); check(12, d, 8'(8'h10 + k), "fifo full order");
        end
        h_read(d); check(12, d, 8'h00, "extra push dropped");
        check(13, {7'b0, fifo_underflow}, 8'h01, "underflow sticky");  // R13

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule